// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address stream for a synchronous burst memory. When a burst begins, it captures a full-width start address. It then produces the remaining three addresses of a four-beat group by itself. Only the two least significant bits move during a burst. They follow an interleaved order or a linear wrapping order, chosen by a static order-select input.

Either of two address strobes starts a burst: one from a processor and one from a cache controller. After the start, an advance input steps the burst. When advance is low, the burst stays on the current address. The block reports two one-cycle indications: that a new burst was loaded, or that the address stepped. The memory array, the data path and the chip-select decode are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the captured address and the beat counter clear. After that edge `cur_addr` is 0 and both `loaded` and `stepped` are 0.
- R2: If `strobe_proc` is high at a rising edge, then after that edge `cur_addr` equals the `ext_addr` sampled at the edge, `loaded` is 1 and `stepped` is 0.
- R3: `strobe_ctrl` starts a burst in exactly the same way as `strobe_proc`. The two strobes act alike whether high alone or together.
- R4: With `order_sel` = 1 (interleaved), the low two bits of `cur_addr` are the captured low bits XOR the beat count (0, 1, 2, 3).
- R5: With `order_sel` = 0 (linear), the low two bits of `cur_addr` are the captured low bits plus the beat count, modulo 4. `order_sel` acts on `cur_addr` combinationally.
- R6: If no strobe is high and `advance` is high at a rising edge, the beat count rises by one. After that edge `stepped` is 1 and `loaded` is 0.
- R7: If no strobe and no `advance` is high at a rising edge, the beat count and the captured address are held. After that edge both flags are 0.
- R8: After the fourth beat (count 3), one more advance wraps the count to 0. `cur_addr` then returns to the first address of the group.
- R9: A strobe takes priority over `advance`. When both are high, the burst reloads with count 0, `loaded` is 1 and `stepped` is 0.
- R10: Bits `cur_addr[ADDR_W-1:2]` stay equal to the captured upper bits for the whole burst, whatever `advance` and `order_sel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | Externally supplied start address |
| strobe_proc | input | 1 | Processor-side address strobe, active high |
| strobe_ctrl | input | 1 | Controller-side address strobe, active high |
| advance | input | 1 | Step to the next beat, active high |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| cur_addr | output | ADDR_W | Current internal burst address |
| loaded | output | 1 | A burst was loaded at the last edge |
| stepped | output | 1 | The address advanced at the last edge |

## Verification
The bench goes after the wrap from beat four back to beat one. A counter that saturates or spills into the upper bits would show a wrong address there. It drives a strobe together with advance: a design that lets advance win would step an old burst instead of loading the new address. It starts a burst from an odd start offset in both orders, so that an XOR confused with an add gives a visibly different sequence (1,2,3,0 against 1,0,3,2). Long random runs with order changes and idle cycles in the middle of a burst show any slip in the hold or in the upper bits.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Width of the in-burst counter: four beats per group.
    localparam int LOW_W = 2;

    typedef logic [LOW_W-1:0] low_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } cmd_e;

    typedef struct packed {
        logic loaded;
        logic stepped;
    } evt_t;

    // Low address bits of a beat, given the start offset and the beat count.
    function automatic low_t beat_low(low_t start, low_t count, order_e ord);
        low_t r;
        if (ord == ORDER_INTERLEAVE)
            r = start ^ count;
        else
            r = low_t'(start + count);
        return r;
    endfunction

endpackage

// File: rtl/burst_decode.sv
module burst_decode
    import burst_pkg::*;
(
    input  logic strobe_proc,
    input  logic strobe_ctrl,
    input  logic advance,
    output cmd_e cmd
);
    // A strobe outranks advance (R9); either strobe loads (R3).
    always_comb begin
        if (strobe_proc || strobe_ctrl)
            cmd = CMD_LOAD;
        else if (advance)
            cmd = CMD_STEP;
        else
            cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_capture.sv
module burst_capture
    import burst_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (cmd == CMD_LOAD)
            base_q <= ext_addr;
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (base_q == $past(ext_addr)));

    assert_keep_base_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> $stable(base_q));
endmodule

// File: rtl/burst_counter.sv
module burst_counter
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd,
    output low_t cnt_q,
    output evt_t evt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            evt_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    cnt_q <= '0;
                    evt_q <= '{loaded: 1'b1, stepped: 1'b0};
                end
                CMD_STEP: begin
                    cnt_q <= low_t'(cnt_q + 1'b1);
                    evt_q <= '{loaded: 1'b0, stepped: 1'b1};
                end
                default: begin
                    evt_q <= '0;
                end
            endcase
        end
    end

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (cnt_q == '0 && evt_q.loaded && !evt_q.stepped));

    assert_step_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (cnt_q == low_t'($past(cnt_q) + 1'b1) && evt_q.stepped));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> ($stable(cnt_q) && evt_q == '0));
endmodule

// File: rtl/burst_order.sv
module burst_order
    import burst_pkg::*;
(
    input  low_t   start_low,
    input  low_t   count,
    input  order_e ord,
    output low_t   beat_lo
);
    assign beat_lo = beat_low(start_low, count, ord);

    // First beat of a group is the captured offset in either order (R4, R5).
    always_comb begin
        if (count == '0)
            assert_first_beat_R5: assert (beat_lo == start_low);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_proc,
    input  logic              strobe_ctrl,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              loaded,
    output logic              stepped
);
    localparam int HI_W = ADDR_W - LOW_W;

    cmd_e              cmd;
    logic [ADDR_W-1:0] base_q;
    low_t              cnt_q;
    evt_t              evt_q;
    low_t              beat_lo;

    burst_decode u_decode (
        .strobe_proc (strobe_proc),
        .strobe_ctrl (strobe_ctrl),
        .advance     (advance),
        .cmd         (cmd)
    );

    burst_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ext_addr (ext_addr),
        .base_q   (base_q)
    );

    burst_counter u_counter (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .cnt_q (cnt_q),
        .evt_q (evt_q)
    );

    burst_order u_order (
        .start_low (base_q[LOW_W-1:0]),
        .count     (cnt_q),
        .ord       (order_e'(order_sel)),
        .beat_lo   (beat_lo)
    );

    assign cur_addr = {base_q[ADDR_W-1 -: HI_W], beat_lo};
    assign loaded   = evt_q.loaded;
    assign stepped  = evt_q.stepped;

    assert_one_flag_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loaded, stepped}));

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && !loaded && !stepped));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int ADDR_W = 15;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] ext_addr;
    logic              strobe_proc, strobe_ctrl, advance, order_sel;
    logic [ADDR_W-1:0] cur_addr;
    logic              loaded, stepped;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench model state
    logic [ADDR_W-1:0] m_base;
    logic [1:0]        m_cnt;
    logic              m_ld, m_st;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr),
        .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
        .advance(advance), .order_sel(order_sel),
        .cur_addr(cur_addr), .loaded(loaded), .stepped(stepped)
    );

    function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] c, logic m);
        return m ? (s ^ c) : 2'(s + c);
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr();
        return {m_base[ADDR_W-1:2], exp_low(m_base[1:0], m_cnt, order_sel)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_model(string tag);
        chk(tag, 32'(cur_addr), 32'(exp_addr()));
        chk(tag, {30'd0, loaded, stepped}, {30'd0, m_ld, m_st});
    endtask

    // Drive at a falling edge, advance the model at the rising edge,
    // and return at the next falling edge for sampling.
    task automatic cycle(logic sp, logic sc, logic adv, logic [ADDR_W-1:0] a);
        strobe_proc = sp;
        strobe_ctrl = sc;
        advance     = adv;
        ext_addr    = a;
        @(posedge clk);
        if (sp || sc) begin
            m_base = a; m_cnt = 2'd0; m_ld = 1'b1; m_st = 1'b0;
        end else if (adv) begin
            m_cnt = m_cnt + 2'd1; m_ld = 1'b0; m_st = 1'b1;
        end else begin
            m_ld = 1'b0; m_st = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; strobe_proc = 0; strobe_ctrl = 0; advance = 0;
        order_sel = 0; ext_addr = '0;
        m_base = '0; m_cnt = 0; m_ld = 0; m_st = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 32'(cur_addr), 32'd0);
        chk("R1", {30'd0, loaded, stepped}, 32'd0);
        rst = 1'b0;

        // R2: processor strobe, linear order, start offset 1
        order_sel = 1'b0;
        cycle(1, 0, 0, 15'h1235);
        chk("R2", 32'(cur_addr), 32'h1235);
        chk("R2", {30'd0, loaded, stepped}, 32'd2);
        // R5: linear 1,2,3,0 then R8 wrap to 1
        cycle(0, 0, 1, 15'h7fff);
        chk("R5", 32'(cur_addr), 32'h1236);
        chk("R6", {30'd0, loaded, stepped}, 32'd1);
        cycle(0, 0, 1, 15'h0);
        chk("R5", 32'(cur_addr), 32'h1237);
        cycle(0, 0, 1, 15'h0);
        chk("R5", 32'(cur_addr), 32'h1234);
        cycle(0, 0, 1, 15'h0);
        chk("R8", 32'(cur_addr), 32'h1235);
        // R7: hold
        cycle(0, 0, 0, 15'h5555);
        chk("R7", 32'(cur_addr), 32'h1235);
        chk("R7", {30'd0, loaded, stepped}, 32'd0);

        // R3: controller strobe, interleaved order, start offset 1: 1,0,3,2
        order_sel = 1'b1;
        cycle(0, 1, 0, 15'h7ff1);
        chk("R3", 32'(cur_addr), 32'h7ff1);
        chk("R3", {30'd0, loaded, stepped}, 32'd2);
        cycle(0, 0, 1, 15'h0);
        chk("R4", 32'(cur_addr), 32'h7ff0);
        cycle(0, 0, 1, 15'h0);
        chk("R4", 32'(cur_addr), 32'h7ff3);
        cycle(0, 0, 1, 15'h0);
        chk("R4", 32'(cur_addr), 32'h7ff2);
        cycle(0, 0, 1, 15'h0);
        chk("R8", 32'(cur_addr), 32'h7ff1);
        chk("R10", 32'(cur_addr[ADDR_W-1:2]), 32'(15'h7ff1 >> 2));

        // R9: strobe with advance reloads
        cycle(0, 0, 1, 15'h0);
        cycle(1, 0, 1, 15'h0a5b);
        chk("R9", 32'(cur_addr), 32'h0a5b);
        chk("R9", {30'd0, loaded, stepped}, 32'd2);
        cycle(1, 1, 1, 15'h0006);
        chk("R9", 32'(cur_addr), 32'h0006);
        chk("R9", {30'd0, loaded, stepped}, 32'd2);

        // Random run against the bench model
        for (int i = 0; i < 4000; i++) begin
            logic sp, sc, adv;
            sp  = ($urandom % 8) == 0;
            sc  = ($urandom % 8) == 0;
            adv = ($urandom % 3) != 0;
            if (($urandom % 16) == 0) order_sel = ~order_sel;
            cycle(sp, sc, adv, ADDR_W'($urandom));
            if (sp || sc)   check_model(sp ? "R2" : "R3");
            else if (adv)   check_model(order_sel ? "R4" : "R5");
            else            check_model("R7");
            chk("R10", 32'(cur_addr[ADDR_W-1:2]), 32'(m_base[ADDR_W-1:2]));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule